// File: doc/BRIEF.md
# Fence Signal Conditional Interrupt Unit

This unit keeps a small bank of fence slots. Each slot holds a 64-bit current value and a 64-bit monitored value. An engine writes new current values through a signal port. The host moves the monitored value through an update port. The unit pulses a host interrupt only when a slot's current value goes strictly above that slot's monitored value. When no interrupt is needed, the host can stay idle.

The monitored value is the smallest value still awaited by the host, minus one. All ones means nobody is waiting, and zero means every nonzero signal interrupts. A signal passes through a two-stage path. The first stage takes a snapshot of the monitored value and the second stage writes the current value and compares it. Because of this, a signal that is in flight while the host changes the monitored value may be compared against the stale threshold.

The update port closes that window with a fixed sequence. It writes the new monitored value, holds off new signals until the signal path is empty, and then resamples the current value against the new threshold. The host reads the resampled value from the completion report. Interrupting slots collect in a pending mask that the host clears by writing ones. A scan-all flag marks the case where interrupts for one slot have merged.

Top module: `fence_irq_unit`

## Requirements
- R1: After reset every current value reads 0, every monitored value is all ones, the pending mask is 0, scan-all and the interrupt pulse are low, and both ready outputs are high.
- R2: A signal accepted at clock edge k writes its full 64-bit value into the slot's current value. Both 32-bit halves become visible together on `rd_value` after edge k+2.
- R3: A signal whose value is strictly greater than the slot's monitored value makes `irq_pulse` high for exactly the cycle after edge k+2 and sets the slot's bit in `pend_mask`. A value less than or equal to the monitored value raises neither.
- R4: While a slot's monitored value is all ones, no signal to that slot interrupts, including a signal of all ones.
- R5: While a slot's monitored value is 0, a signal of 0 does not interrupt and any nonzero signal does.
- R6: An update accepted at edge k writes the monitored value at edge k. Once the signal path holds no signal, the unit compares the slot's current value with the new monitored value. At that edge it pulses `upd_done`, presents the sampled value on `upd_cur`, and pulses the interrupt and sets the pending bit if current > monitored.
- R7: A signal accepted one cycle before an update to the same slot is compared against the old monitored value. The unit must still produce an interrupt and set the pending bit, no later than `upd_done`, when the signal's value exceeds the new monitored value.
- R8: `pend_mask` accumulates across interrupts. Writing a one to a bit of `clr_mask` clears that bit one cycle later and leaves every other bit unchanged.
- R9: `scan_all` rises when an interrupt condition hits a slot whose pending bit is already set. It falls when the pending mask becomes empty.
- R10: An update whose resampled current value is less than or equal to the new monitored value still pulses `upd_done` with that value, but raises no interrupt and sets no pending bit.
- R11: From the cycle after an update is accepted until the cycle after `upd_done`, both `sig_ready` and `upd_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sig_valid | input | 1 | Signal request valid |
| sig_ready | output | 1 | Signal request accepted when high with valid |
| sig_idx | input | 3 | Slot targeted by the signal |
| sig_value | input | 64 | New current value |
| upd_valid | input | 1 | Monitored-value update valid |
| upd_ready | output | 1 | Update accepted when high with valid |
| upd_idx | input | 3 | Slot targeted by the update |
| upd_value | input | 64 | New monitored value |
| upd_done | output | 1 | One-cycle pulse when the resample step has finished |
| upd_cur | output | 64 | Current value sampled by the last finished update |
| rd_idx | input | 3 | Slot selected for a current-value read |
| rd_value | output | 64 | Current value of the selected slot |
| clr_mask | input | 8 | Write-one-to-clear mask for pending bits |
| irq_pulse | output | 1 | One-cycle host interrupt |
| pend_mask | output | 8 | Slots with an unacknowledged interrupt condition |
| scan_all | output | 1 | Set when interrupts for a slot have merged |

## Verification
A stale monitored snapshot or a drain that ends too early shows up as a missing interrupt pulse and a clear pending bit. In the race case this happens within three cycles of the update being accepted, by the time `upd_done` pulses. A wrong compare direction or width shows up at edge k+2 after the signal, as an interrupt on equal or smaller values or as a missed interrupt when only the upper half differs. A corrupt pending or scan-all register can be seen on the next cycle after the hit or the clear that should have changed it.

// File: rtl/fence_irq_pkg.sv
package fence_irq_pkg;

  // Update sequencer state: idle, or waiting for the signal path to drain.
  typedef enum logic [0:0] {
    UPD_IDLE  = 1'b0,
    UPD_DRAIN = 1'b1
  } upd_state_e;

endpackage

// File: rtl/fence_rst_sync.sv
module fence_rst_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);

  logic [1:0] sync_q;

  // Assert asynchronously, release after two clock edges.
  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_out_n = sync_q[1];

endmodule

// File: rtl/fence_slot_bank.sv
module fence_slot_bank #(
  parameter int NUM_SLOTS = 8,
  parameter int VAL_W     = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cur_we,
  input  logic [$clog2(NUM_SLOTS)-1:0] cur_widx,
  input  logic [VAL_W-1:0]             cur_wdata,
  input  logic                         mon_we,
  input  logic [$clog2(NUM_SLOTS)-1:0] mon_widx,
  input  logic [VAL_W-1:0]             mon_wdata,
  input  logic [$clog2(NUM_SLOTS)-1:0] mon_ridx,
  output logic [VAL_W-1:0]             mon_rdata,
  input  logic [$clog2(NUM_SLOTS)-1:0] cur_ridx_a,
  output logic [VAL_W-1:0]             cur_rdata_a,
  input  logic [$clog2(NUM_SLOTS)-1:0] cur_ridx_b,
  output logic [VAL_W-1:0]             cur_rdata_b
);

  localparam int IDX_W = $clog2(NUM_SLOTS);

  logic [VAL_W-1:0] cur_q [NUM_SLOTS];
  logic [VAL_W-1:0] mon_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic cur_en;
    logic mon_en;

    assign cur_en = cur_we && (cur_widx == IDX_W'(g));
    assign mon_en = mon_we && (mon_widx == IDX_W'(g));

    // The full-width value is stored in one register, so both halves always come from the same write.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q[g] <= '0;
      end else if (cur_en) begin
        cur_q[g] <= cur_wdata;
      end
    end

    // A reset value of all ones means there are no waiters.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mon_q[g] <= '1;
      end else if (mon_en) begin
        mon_q[g] <= mon_wdata;
      end
    end
  end

  assign mon_rdata   = mon_q[mon_ridx];
  assign cur_rdata_a = cur_q[cur_ridx_a];
  assign cur_rdata_b = cur_q[cur_ridx_b];

endmodule

// File: rtl/fence_sig_pipe.sv
module fence_sig_pipe #(
  parameter int NUM_SLOTS = 8,
  parameter int VAL_W     = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_acc,
  input  logic [$clog2(NUM_SLOTS)-1:0] in_idx,
  input  logic [VAL_W-1:0]             in_val,
  output logic [$clog2(NUM_SLOTS)-1:0] mon_ridx,
  input  logic [VAL_W-1:0]             mon_rdata,
  output logic                         wr_en,
  output logic [$clog2(NUM_SLOTS)-1:0] wr_idx,
  output logic [VAL_W-1:0]             wr_val,
  output logic [NUM_SLOTS-1:0]         hit_vec,
  output logic                         busy
);

  localparam int IDX_W = $clog2(NUM_SLOTS);

  // Stage A: the accepted request. Stage B: the request plus its monitored snapshot.
  logic             a_vld_q, a_vld_d;
  logic [IDX_W-1:0] a_idx_q, a_idx_d;
  logic [VAL_W-1:0] a_val_q, a_val_d;
  logic             b_vld_q, b_vld_d;
  logic [IDX_W-1:0] b_idx_q, b_idx_d;
  logic [VAL_W-1:0] b_val_q, b_val_d;
  logic [VAL_W-1:0] b_mon_q, b_mon_d;
  logic             b_hit;

  always_comb begin
    a_vld_d = in_acc;
    a_idx_d = a_idx_q;
    a_val_d = a_val_q;
    if (in_acc) begin
      a_idx_d = in_idx;
      a_val_d = in_val;
    end
    b_vld_d = a_vld_q;
    b_idx_d = b_idx_q;
    b_val_d = b_val_q;
    b_mon_d = b_mon_q;
    if (a_vld_q) begin
      b_idx_d = a_idx_q;
      b_val_d = a_val_q;
      b_mon_d = mon_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld_q <= 1'b0;
      a_idx_q <= '0;
      a_val_q <= '0;
      b_vld_q <= 1'b0;
      b_idx_q <= '0;
      b_val_q <= '0;
      b_mon_q <= '1;
    end else begin
      a_vld_q <= a_vld_d;
      a_idx_q <= a_idx_d;
      a_val_q <= a_val_d;
      b_vld_q <= b_vld_d;
      b_idx_q <= b_idx_d;
      b_val_q <= b_val_d;
      b_mon_q <= b_mon_d;
    end
  end

  assign mon_ridx = a_idx_q;
  assign b_hit    = b_vld_q && (b_val_q > b_mon_q);
  assign wr_en    = b_vld_q;
  assign wr_idx   = b_idx_q;
  assign wr_val   = b_val_q;
  assign busy     = a_vld_q || b_vld_q;

  always_comb begin
    hit_vec = '0;
    hit_vec[b_idx_q] = b_hit;
  end

  // A request in stage A always reaches stage B on the next cycle.
  assert_stage_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    a_vld_q |=> (b_vld_q && (b_idx_q == $past(a_idx_q)) && (b_val_q == $past(a_val_q))));

endmodule

// File: rtl/fence_upd_seq.sv
module fence_upd_seq
  import fence_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int VAL_W     = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         upd_valid,
  output logic                         upd_ready,
  input  logic [$clog2(NUM_SLOTS)-1:0] upd_idx,
  input  logic [VAL_W-1:0]             upd_value,
  input  logic                         pipe_busy,
  output logic                         sig_gate,
  output logic                         mon_we,
  output logic [$clog2(NUM_SLOTS)-1:0] mon_widx,
  output logic [VAL_W-1:0]             mon_wdata,
  output logic [$clog2(NUM_SLOTS)-1:0] cur_ridx,
  input  logic [VAL_W-1:0]             cur_rdata,
  output logic [NUM_SLOTS-1:0]         hit_vec,
  output logic                         done_pulse,
  output logic [VAL_W-1:0]             done_value
);

  localparam int IDX_W = $clog2(NUM_SLOTS);

  upd_state_e       state_q, state_d;
  logic [IDX_W-1:0] u_idx_q, u_idx_d;
  logic [VAL_W-1:0] u_val_q, u_val_d;
  logic             done_q, done_d;
  logic [VAL_W-1:0] dval_q, dval_d;
  logic             accept;
  logic             resample;
  logic             res_hit;

  assign upd_ready = (state_q == UPD_IDLE);
  assign sig_gate  = (state_q == UPD_IDLE);
  assign accept    = upd_valid && upd_ready;

  // Step one: the monitored value is written on the accept edge.
  assign mon_we    = accept;
  assign mon_widx  = upd_idx;
  assign mon_wdata = upd_value;

  // Step three: the resample happens only after the signal path has drained.
  assign resample  = (state_q == UPD_DRAIN) && !pipe_busy;
  assign cur_ridx  = u_idx_q;
  assign res_hit   = resample && (cur_rdata > u_val_q);

  always_comb begin
    hit_vec = '0;
    hit_vec[u_idx_q] = res_hit;
  end

  always_comb begin
    state_d = state_q;
    u_idx_d = u_idx_q;
    u_val_d = u_val_q;
    done_d  = 1'b0;
    dval_d  = dval_q;
    unique case (state_q)
      UPD_IDLE: begin
        if (accept) begin
          u_idx_d = upd_idx;
          u_val_d = upd_value;
          state_d = UPD_DRAIN;
        end
      end
      UPD_DRAIN: begin
        if (resample) begin
          done_d  = 1'b1;
          dval_d  = cur_rdata;
          state_d = UPD_IDLE;
        end
      end
      default: state_d = UPD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UPD_IDLE;
      u_idx_q <= '0;
      u_val_q <= '1;
      done_q  <= 1'b0;
      dval_q  <= '0;
    end else begin
      state_q <= state_d;
      u_idx_q <= u_idx_d;
      u_val_q <= u_val_d;
      done_q  <= done_d;
      dval_q  <= dval_d;
    end
  end

  assign done_pulse = done_q;
  assign done_value = dval_q;

  // Completion is only reported after a cycle in which the signal path was empty.
  assert_done_after_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(!pipe_busy));

  // An accepted update closes both request ports on the following cycle.
  assert_ports_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!upd_ready && !sig_gate));

endmodule

// File: rtl/fence_irq_report.sv
module fence_irq_report #(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] hit_sig,
  input  logic [NUM_SLOTS-1:0] hit_upd,
  input  logic [NUM_SLOTS-1:0] clr_mask,
  output logic [NUM_SLOTS-1:0] pend_mask,
  output logic                 scan_all,
  output logic                 irq_pulse
);

  logic [NUM_SLOTS-1:0] pend_q, pend_d;
  logic                 scan_q, scan_d;
  logic                 irq_q, irq_d;
  logic [NUM_SLOTS-1:0] hits;
  logic [NUM_SLOTS-1:0] kept;
  logic                 merged;

  always_comb begin
    hits   = hit_sig | hit_upd;
    kept   = pend_q & ~clr_mask;
    merged = |(hits & kept);
    pend_d = kept | hits;
    scan_d = merged || (scan_q && (pend_d != '0));
    irq_d  = |hits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      scan_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      scan_q <= scan_d;
      irq_q  <= irq_d;
    end
  end

  assign pend_mask = pend_q;
  assign scan_all  = scan_q;
  assign irq_pulse = irq_q;

  assert_irq_has_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (pend_q != '0));

  assert_scan_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_q |-> (pend_q != '0));

endmodule

// File: rtl/fence_irq_unit.sv
module fence_irq_unit #(
  parameter int NUM_SLOTS = 8,
  parameter int VAL_W     = 64,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sig_valid,
  output logic                 sig_ready,
  input  logic [IDX_W-1:0]     sig_idx,
  input  logic [VAL_W-1:0]     sig_value,
  input  logic                 upd_valid,
  output logic                 upd_ready,
  input  logic [IDX_W-1:0]     upd_idx,
  input  logic [VAL_W-1:0]     upd_value,
  output logic                 upd_done,
  output logic [VAL_W-1:0]     upd_cur,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [VAL_W-1:0]     rd_value,
  input  logic [NUM_SLOTS-1:0] clr_mask,
  output logic                 irq_pulse,
  output logic [NUM_SLOTS-1:0] pend_mask,
  output logic                 scan_all
);

  logic                 rst_sync_n;
  logic                 sig_gate;
  logic                 sig_acc;
  logic                 pipe_busy;
  logic [IDX_W-1:0]     pipe_mon_ridx;
  logic [VAL_W-1:0]     pipe_mon_rdata;
  logic                 pipe_wr_en;
  logic [IDX_W-1:0]     pipe_wr_idx;
  logic [VAL_W-1:0]     pipe_wr_val;
  logic [NUM_SLOTS-1:0] pipe_hit_vec;
  logic                 seq_mon_we;
  logic [IDX_W-1:0]     seq_mon_widx;
  logic [VAL_W-1:0]     seq_mon_wdata;
  logic [IDX_W-1:0]     seq_cur_ridx;
  logic [VAL_W-1:0]     seq_cur_rdata;
  logic [NUM_SLOTS-1:0] seq_hit_vec;

  fence_rst_sync u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  // Signals are only taken while no update sequence is running, so the drain has an end.
  assign sig_ready = sig_gate;
  assign sig_acc   = sig_valid && sig_gate;

  fence_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .VAL_W(VAL_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cur_we      (pipe_wr_en),
    .cur_widx    (pipe_wr_idx),
    .cur_wdata   (pipe_wr_val),
    .mon_we      (seq_mon_we),
    .mon_widx    (seq_mon_widx),
    .mon_wdata   (seq_mon_wdata),
    .mon_ridx    (pipe_mon_ridx),
    .mon_rdata   (pipe_mon_rdata),
    .cur_ridx_a  (seq_cur_ridx),
    .cur_rdata_a (seq_cur_rdata),
    .cur_ridx_b  (rd_idx),
    .cur_rdata_b (rd_value)
  );

  fence_sig_pipe #(.NUM_SLOTS(NUM_SLOTS), .VAL_W(VAL_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_acc    (sig_acc),
    .in_idx    (sig_idx),
    .in_val    (sig_value),
    .mon_ridx  (pipe_mon_ridx),
    .mon_rdata (pipe_mon_rdata),
    .wr_en     (pipe_wr_en),
    .wr_idx    (pipe_wr_idx),
    .wr_val    (pipe_wr_val),
    .hit_vec   (pipe_hit_vec),
    .busy      (pipe_busy)
  );

  fence_upd_seq #(.NUM_SLOTS(NUM_SLOTS), .VAL_W(VAL_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .upd_valid  (upd_valid),
    .upd_ready  (upd_ready),
    .upd_idx    (upd_idx),
    .upd_value  (upd_value),
    .pipe_busy  (pipe_busy),
    .sig_gate   (sig_gate),
    .mon_we     (seq_mon_we),
    .mon_widx   (seq_mon_widx),
    .mon_wdata  (seq_mon_wdata),
    .cur_ridx   (seq_cur_ridx),
    .cur_rdata  (seq_cur_rdata),
    .hit_vec    (seq_hit_vec),
    .done_pulse (upd_done),
    .done_value (upd_cur)
  );

  fence_irq_report #(.NUM_SLOTS(NUM_SLOTS)) u_rep (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .hit_sig   (pipe_hit_vec),
    .hit_upd   (seq_hit_vec),
    .clr_mask  (clr_mask),
    .pend_mask (pend_mask),
    .scan_all  (scan_all),
    .irq_pulse (irq_pulse)
  );

  // A signal-path hit always shows up as a pending bit for that slot on the next cycle.
  assert_sig_hit_pends_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pipe_wr_en && (pipe_hit_vec != '0)) |=> (pend_mask[$past(pipe_wr_idx)] && irq_pulse));

  // A resample hit reaches the report at the same edge as the completion pulse.
  assert_resample_hit_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq_hit_vec != '0) |=> (upd_done && irq_pulse && pend_mask[$past(seq_cur_ridx)]));

endmodule

// File: tb/fence_irq_unit_tb_top.sv
module fence_irq_unit_tb_top;

  localparam int NS = 8;
  localparam int VW = 64;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  // Vector table: entry e targets slot e with a monitored value, a signal value and the expected interrupt.
  localparam logic [63:0] T_MON [NS] = '{
    64'd100, 64'd100, 64'd100, ONES, 64'd0, 64'd0,
    64'h0000_0001_0000_0000, 64'hFFFF_FFFF_FFFF_FFFE};
  localparam logic [63:0] T_VAL [NS] = '{
    64'd101, 64'd100, 64'd99, ONES, 64'd1, 64'd0,
    64'h0000_0000_FFFF_FFFF, ONES};
  localparam bit T_EXP [NS] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  logic          clk;
  logic          rst_n;
  logic          sig_valid;
  logic          sig_ready;
  logic [2:0]    sig_idx;
  logic [VW-1:0] sig_value;
  logic          upd_valid;
  logic          upd_ready;
  logic [2:0]    upd_idx;
  logic [VW-1:0] upd_value;
  logic          upd_done;
  logic [VW-1:0] upd_cur;
  logic [2:0]    rd_idx;
  logic [VW-1:0] rd_value;
  logic [NS-1:0] clr_mask;
  logic          irq_pulse;
  logic [NS-1:0] pend_mask;
  logic          scan_all;

  int n_chk;
  int n_fail;

  fence_irq_unit #(.NUM_SLOTS(NS), .VAL_W(VW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_valid (sig_valid),
    .sig_ready (sig_ready),
    .sig_idx   (sig_idx),
    .sig_value (sig_value),
    .upd_valid (upd_valid),
    .upd_ready (upd_ready),
    .upd_idx   (upd_idx),
    .upd_value (upd_value),
    .upd_done  (upd_done),
    .upd_cur   (upd_cur),
    .rd_idx    (rd_idx),
    .rd_value  (rd_value),
    .clr_mask  (clr_mask),
    .irq_pulse (irq_pulse),
    .pend_mask (pend_mask),
    .scan_all  (scan_all)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Signal accepted at edge k; the result is sampled in the cycle after edge k+2.
  task automatic sig_send(input int idx, input logic [63:0] v, output logic irq_seen);
    @(negedge clk);
    sig_valid = 1'b1;
    sig_idx   = 3'(idx);
    sig_value = v;
    @(posedge clk);
    @(negedge clk);
    sig_valid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    irq_seen = irq_pulse;
  endtask

  task automatic upd_send(input int idx, input logic [63:0] v, output int irq_cnt,
                          output logic [63:0] cur);
    bit got;
    got = 1'b0;
    irq_cnt = 0;
    cur = '0;
    @(negedge clk);
    upd_valid = 1'b1;
    upd_idx   = 3'(idx);
    upd_value = v;
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
    chk("R11 sig_ready low during update", 64'(sig_ready), 64'd0);
    chk("R11 upd_ready low during update", 64'(upd_ready), 64'd0);
    for (int i = 0; i < 10; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (irq_pulse) irq_cnt++;
      if (upd_done) begin
        cur = upd_cur;
        got = 1'b1;
        break;
      end
    end
    chk("R6 update completes", 64'(got), 64'd1);
  endtask

  task automatic clr(input logic [NS-1:0] m);
    @(negedge clk);
    clr_mask = m;
    @(posedge clk);
    @(negedge clk);
    clr_mask = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic        irq;
    int          cnt;
    logic [63:0] cur;
    bit          got;
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    sig_valid = 1'b0;
    sig_idx = '0;
    sig_value = '0;
    upd_valid = 1'b0;
    upd_idx = '0;
    upd_value = '0;
    rd_idx = '0;
    clr_mask = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R1: reset state
    chk("R1 pend_mask", 64'(pend_mask), 64'd0);
    chk("R1 scan_all", 64'(scan_all), 64'd0);
    chk("R1 irq_pulse", 64'(irq_pulse), 64'd0);
    chk("R1 sig_ready", 64'(sig_ready), 64'd1);
    chk("R1 upd_ready", 64'(upd_ready), 64'd1);
    for (int s = 0; s < NS; s++) begin
      rd_idx = 3'(s);
      #1;
      chk("R1 current value zero", rd_value, 64'd0);
    end

    // R1 and R4: default monitored value is all ones, so even an all-ones signal stays silent
    sig_send(0, ONES, irq);
    chk("R4 no irq at default threshold", 64'(irq), 64'd0);
    chk("R4 no pending at default threshold", 64'(pend_mask), 64'd0);

    // Table walk covering R2, R3, R4, R5
    for (int e = 0; e < NS; e++) begin
      upd_send(e, T_MON[e], cnt, cur);
      clr('1);
      sig_send(e, T_VAL[e], irq);
      chk("R3 table irq", 64'(irq), 64'(T_EXP[e]));
      chk("R3 table pending bit", 64'(pend_mask[e]), 64'(T_EXP[e]));
      rd_idx = 3'(e);
      #1;
      chk("R2 table current value", rd_value, T_VAL[e]);
    end
    clr('1);

    // R6: raising the waiter threshold below current resamples and interrupts
    upd_send(0, 64'd50, cnt, cur);
    chk("R6 resample irq count", 64'(cnt), 64'd1);
    chk("R6 resampled value", cur, 64'd101);
    chk("R6 pending after resample", 64'(pend_mask), 64'h01);
    clr('1);

    // R10: threshold at or above current completes without interrupt
    upd_send(0, 64'd200, cnt, cur);
    chk("R10 no irq", 64'(cnt), 64'd0);
    chk("R10 resampled value", cur, 64'd101);
    chk("R10 no pending", 64'(pend_mask), 64'd0);

    // R7: signal in flight while the threshold moves
    upd_send(1, ONES, cnt, cur);
    clr('1);
    @(negedge clk);
    sig_valid = 1'b1;
    sig_idx   = 3'd1;
    sig_value = 64'd500;
    @(posedge clk);
    @(negedge clk);
    sig_valid = 1'b0;
    upd_valid = 1'b1;
    upd_idx   = 3'd1;
    upd_value = 64'd300;
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
    cnt = 0;
    got = 1'b0;
    cur = '0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (irq_pulse) cnt++;
      if (upd_done) begin
        got = 1'b1;
        cur = upd_cur;
        break;
      end
    end
    chk("R7 update completes", 64'(got), 64'd1);
    chk("R7 exactly one irq", 64'(cnt), 64'd1);
    chk("R7 resampled value", cur, 64'd500);
    chk("R7 pending bit", 64'(pend_mask), 64'h02);
    clr('1);

    // R8: accumulation and write-one-to-clear
    sig_send(4, 64'd5, irq);
    chk("R5 nonzero signal over zero threshold", 64'(irq), 64'd1);
    sig_send(5, 64'd3, irq);
    chk("R8 second irq", 64'(irq), 64'd1);
    chk("R8 accumulated mask", 64'(pend_mask), 64'h30);
    chk("R9 no merge yet", 64'(scan_all), 64'd0);
    clr(8'h10);
    chk("R8 selective clear", 64'(pend_mask), 64'h20);

    // R9: hit on an already pending slot
    sig_send(5, 64'd4, irq);
    chk("R9 irq on pending slot", 64'(irq), 64'd1);
    chk("R9 scan_all set", 64'(scan_all), 64'd1);
    clr(8'h20);
    chk("R9 mask empty", 64'(pend_mask), 64'd0);
    chk("R9 scan_all cleared", 64'(scan_all), 64'd0);

    finish_run();
  end

endmodule